// File: doc/BRIEF.md
# String Store Block-Fill Engine

This engine carries out a store-string operation for a small processor datapath. When started, it takes an accumulator value, cuts it to one, two or four bytes according to the opcode and operand-size attribute, and writes it to memory at the address held in a destination index. After each write the index moves by the element size: up when the direction flag is clear, down when it is set. A 16-bit address mode uses and updates only the low half of the index, and an out-of-range operand in that mode raises a fault instead of writing.

With the repeat flag set, the engine runs as a block fill. It stores one element per pass and decrements the count register after each pass, until the count reaches zero. The updated index and count stay visible on the outputs after the operation ends. Each memory write is held until the memory acknowledges it.

Control is a six-state machine. IDLE waits for `start` and latches all inputs. It goes to FINISH if repeat is set with a zero count, and to CHECK otherwise. CHECK tests the 16-bit limit and goes to FAULT on a violation or to WRITE if the operand fits. WRITE drives the write and stays there until `mem_ack`, then goes to UPDATE. UPDATE steps the index and count, then returns to CHECK while repeat is set and elements remain, or goes to FINISH. FINISH pulses `done` and FAULT pulses `fault`; both return to IDLE.

Top module: `strfill_engine`

## Requirements
- R1: The element size comes from opcode bit 0 and `opsize32`. Bit 0 = 0 (for example 0xAA) gives a byte with `mem_be`=4'b0001. Bit 0 = 1 (for example 0xAB) gives 16 bits with `mem_be`=4'b0011 when `opsize32`=0, and 32 bits with `mem_be`=4'b1111 when `opsize32`=1. Data is little-endian: `mem_be[k]` enables the byte at `mem_addr`+k, carried in `mem_wdata[8k+7:8k]`. The enabled lanes hold the low bytes of `acc` and the disabled lanes are zero.
- R2: With `addrsize32`=1, `mem_addr` is the full 32-bit index. With `addrsize32`=0, `mem_addr` is {16'h0000, index[15:0]}.
- R3: After each stored element the index grows by the element size (1, 2 or 4) when `dir_down`=0 and shrinks by it when `dir_down`=1. In 32-bit address mode it wraps modulo 2^32.
- R4: With `addrsize32`=0, only the low 16 bits of the index and of the count are used and updated, modulo 2^16. Their upper 16 bits keep their start values.
- R5: With `rep`=1, the engine stores as many elements as the count (after the R4 masking) holds, decrements the count once per element and ends with the count at zero. With `rep`=0 it stores exactly one element and leaves the count unchanged.
- R6: With `rep`=1 and a zero count (after the R4 masking), no write is made. `done` pulses in the first cycle after the start cycle, and the index and count are unchanged.
- R7: With immediate acknowledge, `mem_wr` is high in the second cycle after the start cycle and `done` is high in the fourth. Each further repeated element adds three cycles, and each cycle of acknowledge delay adds one.
- R8: While `mem_wr` is high and `mem_ack` is low, the write stays asserted with address, enables and data unchanged.
- R9: With `addrsize32`=0, an element whose last byte would lie above 0xFFFF is not written. Instead, `fault` pulses for one cycle in the cycle after CHECK and `done` does not pulse. The index and count keep the values reached by the elements already stored.
- R10: A `start` pulse that arrives while an operation is in progress has no effect.
- R11: After reset, `mem_wr`, `done` and `fault` are low and `index_out` and `count_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| opcode | input | 8 | Opcode byte; bit 0 selects byte versus wide element |
| opsize32 | input | 1 | Wide element is 32 bits when 1, 16 bits when 0 |
| addrsize32 | input | 1 | Full 32-bit indexing when 1, 16-bit index and count when 0 |
| dir_down | input | 1 | Direction flag: 0 increments, 1 decrements |
| rep | input | 1 | Repeat as block fill under the count |
| acc | input | 32 | Accumulator value to store |
| index_in | input | 32 | Start value of the destination index |
| count_in | input | 32 | Start value of the element count |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the first enabled lane |
| mem_be | output | 4 | Byte enables, bit k for mem_addr+k |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_ack | input | 1 | Memory accepts the current write |
| index_out | output | 32 | Current destination index |
| count_out | output | 32 | Current count |
| done | output | 1 | One-cycle pulse at normal completion |
| fault | output | 1 | One-cycle pulse on a 16-bit limit violation |

## Verification
A wrong index or count register shows on `index_out`/`count_out` in the cycle after the UPDATE state that produced it. It shows again one element later as a wrong `mem_addr` on the next write. A wrong state transition moves the `mem_wr`, `done` or `fault` pattern by at least one cycle, and the per-cycle comparison catches it in that same cycle. A wrong limit decision shows as a write where a fault was expected, or the reverse, within two cycles of entering CHECK.

// File: rtl/strfill_pkg.sv
package strfill_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_WRITE  = 3'd2,
        ST_UPDATE = 3'd3,
        ST_FINISH = 3'd4,
        ST_FAULT  = 3'd5
    } strfill_state_e;

    // Bytes moved per element: byte form, or wide form at 16 or 32 bits.
    function automatic logic [2:0] elem_bytes(input logic wide, input logic size32);
        if (!wide)
            return 3'd1;
        else if (size32)
            return 3'd4;
        else
            return 3'd2;
    endfunction

endpackage

// File: rtl/strfill_lanes.sv
module strfill_lanes #(
    parameter int DATA_W = 32,
    parameter int STEP_W = 3
) (
    input  logic              wide,
    input  logic              size32,
    input  logic [DATA_W-1:0] acc,
    output logic [STEP_W-1:0] nbytes,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0] wdata
);
    import strfill_pkg::*;

    localparam int BE_W = DATA_W / 8;

    always_comb begin
        nbytes = STEP_W'(elem_bytes(wide, size32));
    end

    for (genvar k = 0; k < BE_W; k++) begin : g_lane
        logic lane_on;
        assign lane_on          = (STEP_W'(k) < nbytes);
        assign be[k]            = lane_on;
        assign wdata[8*k +: 8]  = lane_on ? acc[8*k +: 8] : 8'h00;
    end

endmodule

// File: rtl/strfill_stepper.sv
module strfill_stepper #(
    parameter int ADDR_W  = 32,
    parameter int SHORT_W = 16,
    parameter int STEP_W  = 3
) (
    input  logic [ADDR_W-1:0] index,
    input  logic [ADDR_W-1:0] count,
    input  logic [STEP_W-1:0] nbytes,
    input  logic              dir_down,
    input  logic              addr32,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] next_index,
    output logic [ADDR_W-1:0] next_count,
    output logic              next_count_zero,
    output logic              limit_fault
);
    localparam int HI_W = ADDR_W - SHORT_W;
    localparam logic [SHORT_W:0] SHORT_SPAN = {1'b1, {SHORT_W{1'b0}}};

    logic [ADDR_W-1:0]  step_ext;
    logic [ADDR_W-1:0]  idx_moved;
    logic [ADDR_W-1:0]  cnt_less;
    logic [SHORT_W:0]   short_end;

    always_comb begin
        step_ext  = {{(ADDR_W-STEP_W){1'b0}}, nbytes};
        idx_moved = dir_down ? (index - step_ext) : (index + step_ext);
        cnt_less  = count - {{(ADDR_W-1){1'b0}}, 1'b1};
        short_end = {1'b0, index[SHORT_W-1:0]} + (SHORT_W+1)'(nbytes);

        if (addr32) begin
            eff_addr        = index;
            next_index      = idx_moved;
            next_count      = cnt_less;
            next_count_zero = (cnt_less == '0);
            limit_fault     = 1'b0;
        end else begin
            eff_addr        = {{HI_W{1'b0}}, index[SHORT_W-1:0]};
            next_index      = {index[ADDR_W-1:SHORT_W], idx_moved[SHORT_W-1:0]};
            next_count      = {count[ADDR_W-1:SHORT_W], cnt_less[SHORT_W-1:0]};
            next_count_zero = (cnt_less[SHORT_W-1:0] == '0);
            limit_fault     = (short_end > SHORT_SPAN);
        end
    end

endmodule

// File: rtl/strfill_engine.sv
module strfill_engine #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int SHORT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [7:0]          opcode,
    input  logic                opsize32,
    input  logic                addrsize32,
    input  logic                dir_down,
    input  logic                rep,
    input  logic [DATA_W-1:0]   acc,
    input  logic [ADDR_W-1:0]   index_in,
    input  logic [ADDR_W-1:0]   count_in,
    output logic                mem_wr,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    output logic [ADDR_W-1:0]   index_out,
    output logic [ADDR_W-1:0]   count_out,
    output logic                done,
    output logic                fault
);
    import strfill_pkg::*;

    localparam int BE_W   = DATA_W / 8;
    localparam int STEP_W = $clog2(BE_W) + 1;
    localparam logic [SHORT_W:0] SHORT_SPAN = {1'b1, {SHORT_W{1'b0}}};

    strfill_state_e state_q, state_d;

    logic              wide_q, size32_q, addr32_q, dir_q, rep_q;
    logic [DATA_W-1:0] acc_q;
    logic [ADDR_W-1:0] index_q, count_q;

    logic [STEP_W-1:0] nbytes;
    logic [BE_W-1:0]   lane_be;
    logic [DATA_W-1:0] lane_data;
    logic [ADDR_W-1:0] eff_addr, next_index, next_count;
    logic              next_count_zero, limit_fault;
    logic              start_cnt_zero;

    strfill_lanes #(
        .DATA_W (DATA_W),
        .STEP_W (STEP_W)
    ) u_lanes (
        .wide   (wide_q),
        .size32 (size32_q),
        .acc    (acc_q),
        .nbytes (nbytes),
        .be     (lane_be),
        .wdata  (lane_data)
    );

    strfill_stepper #(
        .ADDR_W  (ADDR_W),
        .SHORT_W (SHORT_W),
        .STEP_W  (STEP_W)
    ) u_stepper (
        .index           (index_q),
        .count           (count_q),
        .nbytes          (nbytes),
        .dir_down        (dir_q),
        .addr32          (addr32_q),
        .eff_addr        (eff_addr),
        .next_index      (next_index),
        .next_count      (next_count),
        .next_count_zero (next_count_zero),
        .limit_fault     (limit_fault)
    );

    always_comb begin
        start_cnt_zero = addrsize32 ? (count_in == '0)
                                    : (count_in[SHORT_W-1:0] == '0);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)
                    state_d = (rep && start_cnt_zero) ? ST_FINISH : ST_CHECK;
            end
            ST_CHECK: begin
                state_d = limit_fault ? ST_FAULT : ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ack)
                    state_d = ST_UPDATE;
            end
            ST_UPDATE: begin
                state_d = (rep_q && !next_count_zero) ? ST_CHECK : ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Operand latch and index/count update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q   <= 1'b0;
            size32_q <= 1'b0;
            addr32_q <= 1'b0;
            dir_q    <= 1'b0;
            rep_q    <= 1'b0;
            acc_q    <= '0;
            index_q  <= '0;
            count_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                wide_q   <= opcode[0];
                size32_q <= opsize32;
                addr32_q <= addrsize32;
                dir_q    <= dir_down;
                rep_q    <= rep;
                acc_q    <= acc;
                index_q  <= index_in;
                count_q  <= count_in;
            end else if (state_q == ST_UPDATE) begin
                index_q <= next_index;
                if (rep_q)
                    count_q <= next_count;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_wr    = (state_q == ST_WRITE);
        mem_addr  = eff_addr;
        mem_be    = mem_wr ? lane_be : '0;
        mem_wdata = mem_wr ? lane_data : '0;
        done      = (state_q == ST_FINISH);
        fault     = (state_q == ST_FAULT);
        index_out = index_q;
        count_out = count_q;
    end

    // Checks next to the logic they guard
    assert_be_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_be[0] && ($countones(mem_be) == int'(nbytes))));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDATE && addr32_q) |=>
        (($past(dir_q) ? ($past(index_q) - index_q) : (index_q - $past(index_q)))
            == ADDR_W'($past(nbytes))));

    assert_upper_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDATE && !addr32_q) |=>
        (index_q[ADDR_W-1:SHORT_W] == $past(index_q[ADDR_W-1:SHORT_W]) &&
         count_q[ADDR_W-1:SHORT_W] == $past(count_q[ADDR_W-1:SHORT_W])));

    assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ack) |=>
        (mem_wr && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)));

    assert_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !addr32_q) |->
        (({1'b0, mem_addr[SHORT_W-1:0]} + (SHORT_W+1)'(nbytes)) <= SHORT_SPAN));

    assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!fault && !done && !mem_wr));

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_WRITE) |=> $stable(index_q));

endmodule

// File: tb/test_strfill_engine.sv
`timescale 1ns/1ps
module test_strfill_engine;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic        done;
        logic        fault;
        logic [31:0] idx;
        logic [31:0] cnt;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        opsize32 = 1'b0, addrsize32 = 1'b0, dir_down = 1'b0, rep = 1'b0;
    logic [31:0] acc = '0, index_in = '0, count_in = '0;
    logic        mem_wr, mem_ack, done, fault;
    logic [31:0] mem_addr, mem_wdata, index_out, count_out;
    logic [3:0]  mem_be;

    int n_cmp = 0;
    int n_bad = 0;
    int ack_delay = 0;
    int wr_seen = 0;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    strfill_engine i_strfill_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .opsize32(opsize32), .addrsize32(addrsize32), .dir_down(dir_down),
        .rep(rep), .acc(acc), .index_in(index_in), .count_in(count_in),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .index_out(index_out),
        .count_out(count_out), .done(done), .fault(fault)
    );

    // Memory responder: acknowledges after ack_delay waiting cycles
    initial mem_ack = 1'b0;
    always @(negedge clk) begin
        if (mem_wr) begin
            mem_ack <= (wr_seen == ack_delay);
            wr_seen <= wr_seen + 1;
        end else begin
            mem_ack <= 1'b0;
            wr_seen <= 0;
        end
    end

    function automatic exp_t mk(logic wr, logic [31:0] a, logic [3:0] b, logic [31:0] d,
                                logic dn, logic ft, logic [31:0] ix, logic [31:0] cn);
        exp_t e;
        e.wr = wr; e.addr = a; e.be = b; e.data = d;
        e.done = dn; e.fault = ft; e.idx = ix; e.cnt = cn;
        return e;
    endfunction

    task automatic check(exp_t e, string tag);
        bit bad;
        n_cmp++;
        bad = (mem_wr !== e.wr) || (done !== e.done) || (fault !== e.fault) ||
              (index_out !== e.idx) || (count_out !== e.cnt);
        if (e.wr && ((mem_addr !== e.addr) || (mem_be !== e.be) || (mem_wdata !== e.data)))
            bad = 1'b1;
        if (bad) begin
            n_bad++;
            $display("FAIL %s t=%0t actual wr=%b addr=%h be=%h data=%h done=%b fault=%b idx=%h cnt=%h expected wr=%b addr=%h be=%h data=%h done=%b fault=%b idx=%h cnt=%h",
                tag, $time, mem_wr, mem_addr, mem_be, mem_wdata, done, fault, index_out, count_out,
                e.wr, e.addr, e.be, e.data, e.done, e.fault, e.idx, e.cnt);
        end
    endtask

    // Behavioural reference: expected output per cycle after the start cycle
    task automatic build(logic [7:0] opc, logic o32, logic a32, logic dn, logic rp,
                         logic [31:0] ac, logic [31:0] ix, logic [31:0] cn, int dly);
        int n;
        logic [31:0] mi, mc, ad, dat;
        logic [3:0]  b;
        logic [15:0] lo;
        n   = !opc[0] ? 1 : (o32 ? 4 : 2);
        b   = (n == 1) ? 4'h1 : ((n == 2) ? 4'h3 : 4'hF);
        dat = (n == 1) ? {24'h0, ac[7:0]} : ((n == 2) ? {16'h0, ac[15:0]} : ac);
        mi = ix; mc = cn;
        if (rp && (a32 ? (mc == 0) : (mc[15:0] == 0))) begin
            expq.push_back(mk(0, 0, 0, 0, 1, 0, mi, mc));
            return;
        end
        while (1) begin
            expq.push_back(mk(0, 0, 0, 0, 0, 0, mi, mc));
            if (!a32 && (int'(mi[15:0]) + n > 65536)) begin
                expq.push_back(mk(0, 0, 0, 0, 0, 1, mi, mc));
                break;
            end
            ad = a32 ? mi : {16'h0, mi[15:0]};
            for (int w = 0; w <= dly; w++)
                expq.push_back(mk(1, ad, b, dat, 0, 0, mi, mc));
            expq.push_back(mk(0, 0, 0, 0, 0, 0, mi, mc));
            if (a32) begin
                mi = dn ? mi - n : mi + n;
                if (rp) mc = mc - 1;
            end else begin
                lo = dn ? mi[15:0] - 16'(n) : mi[15:0] + 16'(n);
                mi = {mi[31:16], lo};
                if (rp) mc = {mc[31:16], mc[15:0] - 16'h1};
            end
            if (!rp || (a32 ? (mc == 0) : (mc[15:0] == 0))) begin
                expq.push_back(mk(0, 0, 0, 0, 1, 0, mi, mc));
                break;
            end
        end
        // two quiet cycles after completion
        expq.push_back(mk(0, 0, 0, 0, 0, 0, mi, mc));
        expq.push_back(mk(0, 0, 0, 0, 0, 0, mi, mc));
    endtask

    task automatic run_op(string tag, logic [7:0] opc, logic o32, logic a32, logic dn,
                          logic rp, logic [31:0] ac, logic [31:0] ix, logic [31:0] cn,
                          int dly, bit restart);
        int k;
        build(opc, o32, a32, dn, rp, ac, ix, cn, dly);
        @(negedge clk);
        opcode = opc; opsize32 = o32; addrsize32 = a32; dir_down = dn; rep = rp;
        acc = ac; index_in = ix; count_in = cn; ack_delay = dly; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (expq.size() > 0) begin
            check(expq.pop_front(), tag);
            k++;
            if (restart && k == 2) begin
                // R10: second request during the write, different operands
                index_in = 32'h5555_0000; count_in = 32'h0; acc = 32'hDEAD_BEEF;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (expq.size() > 0) @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs at reset
        check(mk(0, 0, 0, 0, 0, 0, 32'h0, 32'h0), "R11 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(mk(0, 0, 0, 0, 0, 0, 32'h0, 32'h0), "R11 after reset");

        // R1 R7: byte store, 32-bit address, up
        run_op("R1 R7 byte", 8'hAA, 1'b1, 1'b1, 1'b0, 1'b0, 32'h1122_3344, 32'h0000_1000, 32'h7, 0, 0);
        // R1 R2 R4: word, 16-bit address, down; count unchanged (R5)
        run_op("R1 R2 R4 word", 8'hAB, 1'b0, 1'b0, 1'b1, 1'b0, 32'hA5B6_C7D8, 32'hABCD_1234, 32'h9, 0, 0);
        // R3: dword up with 32-bit wrap
        run_op("R1 R3 dword wrap", 8'hAB, 1'b1, 1'b1, 1'b0, 1'b0, 32'hCAFE_F00D, 32'hFFFF_FFFE, 32'h0, 0, 0);
        // R5 R8: repeated dwords with delayed acknowledge
        run_op("R5 R8 fill", 8'hAB, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0102_0304, 32'h0000_2000, 32'h3, 2, 0);
        // R3 R5: repeated words downward, 32-bit address
        run_op("R3 R5 down", 8'hAB, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_BEEF, 32'h0000_0010, 32'h2, 1, 0);
        // R6: zero count, 32-bit and masked 16-bit
        run_op("R6 zero", 8'hAA, 1'b0, 1'b1, 1'b0, 1'b1, 32'h55, 32'h0000_3000, 32'h0, 0, 0);
        run_op("R6 R4 masked zero", 8'hAB, 1'b1, 1'b0, 1'b0, 1'b1, 32'h55, 32'h0000_3000, 32'h0005_0000, 0, 0);
        // R4: 16-bit wrap of index and count, upper halves kept
        run_op("R4 byte wrap", 8'hAA, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_00EE, 32'h7777_0001, 32'h9999_0003, 0, 0);
        // R9: immediate limit fault, then fault after one stored element
        run_op("R9 fault now", 8'hAB, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h1234_FFFE, 32'h0, 0, 0);
        run_op("R9 fault mid", 8'hAB, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8765_4321, 32'h0000_FFFA, 32'h3, 0, 0);
        run_op("R9 word edge ok", 8'hAB, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_ABCD, 32'h0000_FFFE, 32'h0, 0, 0);
        // R10: start during a write is ignored
        run_op("R10 restart", 8'hAB, 1'b1, 1'b1, 1'b0, 1'b0, 32'h1357_9BDF, 32'h0000_4000, 32'h1, 3, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule